// File: doc/BRIEF.md
# Majority-Logic In-Memory Compute Engine

This block is a small programmable engine in which the storage array is also the arithmetic unit. A compute memory of `NWORDS` words, each `WBITS` wide, holds state. One compute instruction updates every enabled bit of one addressed word at once. The new value of each bit is the three-input majority of three things: the bit's own stored value, a wordline value shared by the whole word, and the inverse of that bit's own bitline value. Majority together with inversion can build any Boolean function, so a program made only of such updates and of word reads can compute arbitrary logic across a whole word in parallel.

A program sits in an external instruction memory. The engine addresses it with a program counter and runs each instruction through three stages: fetch, decode and execute. Two operand registers feed the compute instruction. One is a primary-input register that the host loads over a valid/ready port. The other is a data register that the read instruction fills from the array. The host pulses `start` and waits for `done`. While a program runs, `pir_ready` is low, so the host must hold `pir_valid` and `pir_data` until ready comes back. The primary input therefore stays fixed for the whole run. A debug port reads any word of the array at any time.

Top module: `mlim_engine`

## Requirements
- R1: A legal compute instruction (opcode 2'b10) sets each enabled bit i of the addressed word, at one clock edge, to Z' = (Z&wl)|(Z&~bl_i)|(wl&~bl_i), where Z is the stored bit, wl is the wordline value and bl_i is the bit's bitline value.
- R2: A bit whose bitline enable flag is 0 keeps its stored value through a compute instruction.
- R3: Field `s` selects the operand source: 0 selects the primary-input register and 1 selects the data register. The 2-bit index of each bitline picks which source bit drives that bitline.
- R4: The 2-bit wordline select drives wl as follows: 2'b11 gives 1, 2'b10 gives 0, and 2'b00 gives the source bit chosen by the 2-bit field `wb`.
- R5: A compute instruction whose wordline select is 2'b01 leaves the array unchanged and sets `illegal`. `illegal` stays set until the next accepted `start`.
- R6: A read instruction (opcode 2'b01) copies the addressed word into the data register. A compute instruction placed directly after the read already sees the new value.
- R7: A halt instruction (opcode 2'b11) stops the program counter at the halt's own address. `done` rises once the halt has executed, and it holds until the next accepted `start`. Instructions after the halt have no effect.
- R8: When the instruction at the last instruction-memory address is fetched and is not a halt, it still executes and then ends the run as a halt would, with the program counter left on that address.
- R9: `pir_data` is taken into the primary-input register in any cycle where `pir_valid` and `pir_ready` are both high. `pir_ready` is low while the engine is busy.
- R10: After reset the array reads all zeros, and `busy`, `done` and `illegal` are 0.
- R11: The instruction word has these fields, from the LSB up: opcode[1:0] (2'b00 is a no-op), address, `s`, wordline select[1:0], `wb`, and then one group per bitline i, made of a bitline index followed by an enable bit. A no-op changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a program at address 0 when the engine is idle |
| busy | output | 1 | A program is running |
| done | output | 1 | The last program has finished; holds until the next start |
| illegal | output | 1 | Sticky flag: an invalid wordline select was seen in this run |
| imem_addr | output | PC_W | Instruction memory address (the program counter) |
| imem_data | input | INSTR_W | Instruction word at `imem_addr`, combinational |
| pir_valid | input | 1 | Primary-input load request |
| pir_ready | output | 1 | Primary-input load accepted this cycle when high |
| pir_data | input | WBITS | Primary-input value |
| dbg_addr | input | ADDR_W | Debug read address |
| dbg_data | output | WBITS | Array word at `dbg_addr` |

## Verification
The bench builds the engine with 4-bit words, 8 words and an 8-entry instruction memory. At that size a 2-bit bitline index can reach every source bit, and a word's full state can be compared in one debug read. The small program memory also lets the run-off-the-end case be reached with a program only eight instructions long. The bench checks both operand sources, all three legal wordline codes, masked bitlines, a read followed at once by a compute, the illegal code, halting, and loads attempted while the engine is busy.

// File: rtl/mlim_pkg.sv
package mlim_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_READ  = 2'b01,
    OP_APPLY = 2'b10,
    OP_HALT  = 2'b11
  } op_e;

  localparam logic [1:0] WS_ONE  = 2'b11;
  localparam logic [1:0] WS_ZERO = 2'b10;
  localparam logic [1:0] WS_SRC  = 2'b00;
  localparam logic [1:0] WS_BAD  = 2'b01;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/mlim_fetch.sv
module mlim_fetch #(
  parameter int INSTR_W = 22,
  parameter int DEPTH   = 8,
  localparam int PC_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  output logic [PC_W-1:0]    pc,
  input  logic [INSTR_W-1:0] imem_data,
  output logic               fetching,
  output logic               if_valid,
  output logic [INSTR_W-1:0] if_instr,
  output logic               if_term
);
  import mlim_pkg::*;
  localparam logic [PC_W-1:0] LAST = PC_W'(DEPTH - 1);

  logic term_now;
  assign term_now = (imem_data[1:0] == OP_HALT) || (pc == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetching <= 1'b0;
      pc       <= '0;
      if_valid <= 1'b0;
      if_instr <= '0;
      if_term  <= 1'b0;
    end else if (launch) begin
      fetching <= 1'b1;
      pc       <= '0;
      if_valid <= 1'b0;
    end else if (fetching) begin
      if_valid <= 1'b1;
      if_instr <= imem_data;
      if_term  <= term_now;
      fetching <= !term_now;
      if (!term_now) pc <= pc + 1'b1;
    end else begin
      if_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mlim_decode.sv
module mlim_decode #(
  parameter int WBITS    = 4,
  parameter int NWORDS   = 8,
  localparam int ADDR_W  = $clog2(NWORDS),
  localparam int IDX_W   = $clog2(WBITS),
  localparam int S_BIT   = 2 + ADDR_W,
  localparam int WS_LSB  = S_BIT + 1,
  localparam int WB_LSB  = WS_LSB + 2,
  localparam int BL_LSB  = WB_LSB + IDX_W,
  localparam int BL_W    = IDX_W + 1,
  localparam int INSTR_W = BL_LSB + WBITS * BL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   launch,
  input  logic                   if_valid,
  input  logic [INSTR_W-1:0]     if_instr,
  input  logic                   if_term,
  output logic                   id_valid,
  output logic [1:0]             id_op,
  output logic [ADDR_W-1:0]      id_addr,
  output logic                   id_s,
  output logic [1:0]             id_ws,
  output logic [IDX_W-1:0]       id_wb,
  output logic [WBITS-1:0]       id_ven,
  output logic [WBITS*IDX_W-1:0] id_vals,
  output logic                   id_term
);
  logic [WBITS-1:0]       ven_d;
  logic [WBITS*IDX_W-1:0] vals_d;

  for (genvar i = 0; i < WBITS; i++) begin : g_bl
    assign vals_d[i*IDX_W +: IDX_W] = if_instr[BL_LSB + i*BL_W +: IDX_W];
    assign ven_d[i]                 = if_instr[BL_LSB + i*BL_W + IDX_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || launch) begin
      id_valid <= 1'b0;
      id_op    <= '0;
      id_addr  <= '0;
      id_s     <= 1'b0;
      id_ws    <= '0;
      id_wb    <= '0;
      id_ven   <= '0;
      id_vals  <= '0;
      id_term  <= 1'b0;
    end else begin
      id_valid <= if_valid;
      id_op    <= if_instr[1:0];
      id_addr  <= if_instr[2 +: ADDR_W];
      id_s     <= if_instr[S_BIT];
      id_ws    <= if_instr[WS_LSB +: 2];
      id_wb    <= if_instr[WB_LSB +: IDX_W];
      id_ven   <= ven_d;
      id_vals  <= vals_d;
      id_term  <= if_term;
    end
  end
endmodule

// File: rtl/mlim_array.sv
module mlim_array #(
  parameter int WBITS   = 4,
  parameter int NWORDS  = 8,
  localparam int ADDR_W = $clog2(NWORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    apply_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wl,
  input  logic [WBITS-1:0]        bl_en,
  input  logic [WBITS-1:0]        bl,
  output logic [NWORDS*WBITS-1:0] cells
);
  import mlim_pkg::*;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WBITS-1:0] word_q, word_d;

    always_comb begin
      for (int b = 0; b < WBITS; b++)
        word_d[b] = bl_en[b] ? maj3(word_q[b], wl, ~bl[b]) : word_q[b];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                                 word_q <= '0;
      else if (apply_en && addr == ADDR_W'(w))    word_q <= word_d;
    end

    assign cells[w*WBITS +: WBITS] = word_q;
  end
endmodule

// File: rtl/mlim_engine.sv
module mlim_engine #(
  parameter int WBITS      = 4,
  parameter int NWORDS     = 8,
  parameter int IMEM_DEPTH = 8,
  localparam int ADDR_W    = $clog2(NWORDS),
  localparam int IDX_W     = $clog2(WBITS),
  localparam int PC_W      = $clog2(IMEM_DEPTH),
  localparam int INSTR_W   = 2 + ADDR_W + 1 + 2 + IDX_W + WBITS * (IDX_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               illegal,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  input  logic               pir_valid,
  output logic               pir_ready,
  input  logic [WBITS-1:0]   pir_data,
  input  logic [ADDR_W-1:0]  dbg_addr,
  output logic [WBITS-1:0]   dbg_data
);
  import mlim_pkg::*;

  logic                   launch, fetching;
  logic                   if_valid, if_term;
  logic [INSTR_W-1:0]     if_instr;
  logic                   id_valid, id_s, id_term;
  logic [1:0]             id_op, id_ws;
  logic [ADDR_W-1:0]      id_addr;
  logic [IDX_W-1:0]       id_wb;
  logic [WBITS-1:0]       id_ven;
  logic [WBITS*IDX_W-1:0] id_vals;
  logic [WBITS-1:0]       pir_q, dmr_q, src, bl;
  logic [NWORDS*WBITS-1:0] mem_flat;
  logic                   wl, apply_en, bad_ws;

  assign launch    = start && !busy;
  assign pir_ready = !busy;

  mlim_fetch #(.INSTR_W(INSTR_W), .DEPTH(IMEM_DEPTH)) u_fetch (
    .clk, .rst_n, .launch, .pc(imem_addr), .imem_data, .fetching,
    .if_valid, .if_instr, .if_term
  );

  mlim_decode #(.WBITS(WBITS), .NWORDS(NWORDS)) u_decode (
    .clk, .rst_n, .launch, .if_valid, .if_instr, .if_term,
    .id_valid, .id_op, .id_addr, .id_s, .id_ws, .id_wb, .id_ven, .id_vals, .id_term
  );

  // Execute: operands resolve here from registered sources, so a read in the
  // previous cycle is already visible in dmr_q.
  assign src = id_s ? dmr_q : pir_q;

  always_comb begin
    unique case (id_ws)
      WS_ONE:  wl = 1'b1;
      WS_ZERO: wl = 1'b0;
      default: wl = src[id_wb];
    endcase
  end

  for (genvar i = 0; i < WBITS; i++) begin : g_route
    assign bl[i] = src[id_vals[i*IDX_W +: IDX_W]];
  end

  assign bad_ws   = id_valid && (id_op == OP_APPLY) && (id_ws == WS_BAD);
  assign apply_en = id_valid && (id_op == OP_APPLY) && (id_ws != WS_BAD);

  mlim_array #(.WBITS(WBITS), .NWORDS(NWORDS)) u_array (
    .clk, .rst_n, .apply_en, .addr(id_addr), .wl, .bl_en(id_ven), .bl, .cells(mem_flat)
  );

  assign dbg_data = mem_flat[dbg_addr*WBITS +: WBITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
      pir_q   <= '0;
      dmr_q   <= '0;
    end else begin
      if (pir_valid && pir_ready) pir_q <= pir_data;
      if (launch) begin
        busy    <= 1'b1;
        done    <= 1'b0;
        illegal <= 1'b0;
      end else begin
        if (bad_ws) illegal <= 1'b1;
        if (id_valid && id_op == OP_READ) dmr_q <= mem_flat[id_addr*WBITS +: WBITS];
        if (id_valid && id_term) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mlim_engine_chk.sv
module mlim_engine_chk #(
  parameter int WBITS  = 4,
  parameter int NWORDS = 8,
  parameter int PC_W   = 3,
  parameter int ADDR_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    launch,
  input logic                    done,
  input logic                    busy,
  input logic                    illegal,
  input logic                    pir_valid,
  input logic                    pir_ready,
  input logic [WBITS-1:0]        pir_data,
  input logic [WBITS-1:0]        pir_q,
  input logic [WBITS-1:0]        dmr_q,
  input logic [PC_W-1:0]         pc,
  input logic                    fetching,
  input logic                    id_valid,
  input logic [1:0]              id_op,
  input logic [1:0]              id_ws,
  input logic [ADDR_W-1:0]       id_addr,
  input logic [NWORDS*WBITS-1:0] mem_flat
);
  AST_BAD_WS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_op == 2'b10 && id_ws == 2'b01) |=> $stable(mem_flat)); // R5
  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !launch) |=> illegal); // R5
  AST_READ_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_op == 2'b01) |=> dmr_q == $past(mem_flat[id_addr*WBITS +: WBITS])); // R6
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetching && !launch) |=> $stable(pc)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !launch) |=> done); // R7
  AST_PIR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pir_valid && pir_ready) |=> pir_q == $past(pir_data)); // R9
  AST_PIR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pir_q)); // R9
endmodule

bind mlim_engine mlim_engine_chk #(
  .WBITS(WBITS), .NWORDS(NWORDS), .PC_W(PC_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .done(done), .busy(busy),
  .illegal(illegal), .pir_valid(pir_valid), .pir_ready(pir_ready),
  .pir_data(pir_data), .pir_q(pir_q), .dmr_q(dmr_q), .pc(imem_addr),
  .fetching(fetching), .id_valid(id_valid), .id_op(id_op), .id_ws(id_ws),
  .id_addr(id_addr), .mem_flat(mem_flat)
);

// File: tb/mlim_engine_bench.sv
`timescale 1ns/1ps
module mlim_engine_bench;
  localparam int WB = 4, NW = 8, DEP = 8, IW = 22;

  typedef struct packed {
    logic [3:0] pir;
    logic [1:0] op;
    logic [2:0] addr;
    logic       s;
    logic [1:0] ws;
    logic [1:0] wb;
    logic [3:0] vm;
    logic [7:0] vals;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{4'b0101, 2'b10, 3'd1, 1'b0, 2'b11, 2'd0, 4'b1111, 8'hE4}, // R1 wl=1
    '{4'b1111, 2'b10, 3'd1, 1'b0, 2'b10, 2'd0, 4'b0011, 8'hE4}, // R2 masked
    '{4'b0010, 2'b10, 3'd2, 1'b0, 2'b00, 2'd1, 4'b1111, 8'h00}, // R4 wl from wb
    '{4'b1111, 2'b10, 3'd2, 1'b0, 2'b10, 2'd0, 4'b1010, 8'h00}, // R2 odd bits
    '{4'b0000, 2'b01, 3'd1, 1'b0, 2'b00, 2'd0, 4'b0000, 8'h00}, // R6 read
    '{4'b0000, 2'b10, 3'd3, 1'b1, 2'b11, 2'd0, 4'b1111, 8'h1B}, // R3 dmr reversed
    '{4'b1000, 2'b10, 3'd3, 1'b0, 2'b00, 2'd3, 4'b0101, 8'h02}, // R3 index pick
    '{4'b0110, 2'b00, 3'd3, 1'b0, 2'b11, 2'd0, 4'b1111, 8'hE4}  // R11 no-op
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, illegal, pir_ready;
  logic [2:0] imem_addr;
  logic [IW-1:0] imem_data;
  logic pir_valid = 1'b0;
  logic [3:0] pir_data = '0;
  logic [2:0] dbg_addr = '0;
  logic [3:0] dbg_data;
  logic [IW-1:0] imem [DEP];

  int n_chk = 0, n_fail = 0;
  logic [3:0] mdl_mem [NW];
  logic [3:0] mdl_dmr, mdl_pir;

  always #2 clk = ~clk;
  assign imem_data = imem[imem_addr];

  mlim_engine #(.WBITS(WB), .NWORDS(NW), .IMEM_DEPTH(DEP)) u_mlim_engine (
    .clk, .rst_n, .start, .busy, .done, .illegal, .imem_addr, .imem_data,
    .pir_valid, .pir_ready, .pir_data, .dbg_addr, .dbg_data
  );

  function automatic logic [IW-1:0] mk(input logic [1:0] op, input logic [2:0] addr,
      input logic s, input logic [1:0] ws, input logic [1:0] wb,
      input logic [3:0] vm, input logic [7:0] vals);
    logic [IW-1:0] r;
    r = '0;
    r[1:0] = op; r[4:2] = addr; r[5] = s; r[7:6] = ws; r[9:8] = wb;
    for (int i = 0; i < 4; i++) begin
      r[10 + 3*i +: 2] = vals[2*i +: 2];
      r[12 + 3*i]      = vm[i];
    end
    return r;
  endfunction

  function automatic logic [3:0] mdl_apply(input logic [3:0] z, input logic [3:0] src,
      input logic [1:0] ws, input logic [1:0] wb, input logic [3:0] vm, input logic [7:0] vals);
    logic w, b;
    logic [3:0] r;
    w = (ws == 2'b11) ? 1'b1 : (ws == 2'b10) ? 1'b0 : src[wb];
    r = z;
    for (int i = 0; i < 4; i++) begin
      b = src[vals[2*i +: 2]];
      if (vm[i]) r[i] = (z[i] & w) | (z[i] & ~b) | (w & ~b);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_pir(input logic [3:0] v);
    @(negedge clk);
    pir_valid = 1'b1; pir_data = v;
    @(negedge clk);
    pir_valid = 1'b0;
    mdl_pir = v;
  endtask

  task automatic clear_imem();
    for (int i = 0; i < DEP; i++) imem[i] = mk(2'b00, 3'd0, 1'b0, 2'b11, 2'd0, 4'b0, 8'h0);
  endtask

  task automatic run(input string req);
    int cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 0;
    while (!done && cnt < 200) begin @(negedge clk); cnt++; end
    check(done === 1'b1, req, done, 1);
  endtask

  task automatic peek(input logic [2:0] a, input string req);
    @(negedge clk); dbg_addr = a; #1;
    check(dbg_data === mdl_mem[a], req, dbg_data, mdl_mem[a]);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ok;
    for (int i = 0; i < NW; i++) mdl_mem[i] = '0;
    mdl_dmr = '0; mdl_pir = '0;
    clear_imem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(busy === 0 && done === 0 && illegal === 0, "R10 flags", {busy, done, illegal}, 0);
    check(pir_ready === 1'b1, "R9 ready idle", pir_ready, 1);
    ok = 1'b1;
    for (int a = 0; a < NW; a++) begin
      dbg_addr = 3'(a); #1;
      if (dbg_data !== 4'b0) ok = 1'b0;
    end
    check(ok, "R10 array zero", ok, 1);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      load_pir(VECS[v].pir);
      clear_imem();
      imem[0] = mk(VECS[v].op, VECS[v].addr, VECS[v].s, VECS[v].ws, VECS[v].wb, VECS[v].vm, VECS[v].vals);
      imem[1] = mk(2'b11, 3'd0, 1'b0, 2'b11, 2'd0, 4'b0, 8'h0);
      run("R7 done");
      if (VECS[v].op == 2'b01) mdl_dmr = mdl_mem[VECS[v].addr];
      else if (VECS[v].op == 2'b10)
        mdl_mem[VECS[v].addr] = mdl_apply(mdl_mem[VECS[v].addr],
          VECS[v].s ? mdl_dmr : mdl_pir, VECS[v].ws, VECS[v].wb, VECS[v].vm, VECS[v].vals);
      peek(VECS[v].addr, "R1 vector word");
    end

    // R6 read then compute back to back
    clear_imem();
    imem[0] = mk(2'b01, 3'd2, 1'b0, 2'b11, 2'd0, 4'b0, 8'h0);
    imem[1] = mk(2'b10, 3'd4, 1'b1, 2'b11, 2'd0, 4'b1111, 8'hE4);
    imem[2] = mk(2'b11, 3'd0, 1'b0, 2'b11, 2'd0, 4'b0, 8'h0);
    run("R6 done");
    mdl_dmr = mdl_mem[2];
    mdl_mem[4] = mdl_apply(mdl_mem[4], mdl_dmr, 2'b11, 2'd0, 4'b1111, 8'hE4);
    peek(3'd4, "R6 forwarded read");

    // R5 illegal wordline select
    clear_imem();
    imem[0] = mk(2'b10, 3'd1, 1'b0, 2'b01, 2'd0, 4'b1111, 8'hE4);
    imem[1] = mk(2'b11, 3'd0, 1'b0, 2'b11, 2'd0, 4'b0, 8'h0);
    run("R5 done");
    check(illegal === 1'b1, "R5 flag set", illegal, 1);
    peek(3'd1, "R5 word kept");
    clear_imem();
    imem[0] = mk(2'b11, 3'd0, 1'b0, 2'b11, 2'd0, 4'b0, 8'h0);
    run("R5 rerun");
    check(illegal === 1'b0, "R5 flag cleared", illegal, 0);

    // R7 halt stops further instructions
    clear_imem();
    imem[0] = mk(2'b11, 3'd0, 1'b0, 2'b11, 2'd0, 4'b0, 8'h0);
    imem[1] = mk(2'b10, 3'd7, 1'b0, 2'b11, 2'd0, 4'b1111, 8'hE4);
    run("R7 halt");
    repeat (4) @(negedge clk);
    check(imem_addr === 3'd0, "R7 pc held", imem_addr, 0);
    check(done === 1'b1, "R7 done holds", done, 1);
    peek(3'd7, "R7 after halt");

    // R8 end of program memory without halt
    load_pir(4'b0011);
    clear_imem();
    imem[7] = mk(2'b10, 3'd5, 1'b0, 2'b11, 2'd0, 4'b1111, 8'hE4);
    run("R8 done");
    mdl_mem[5] = mdl_apply(mdl_mem[5], mdl_pir, 2'b11, 2'd0, 4'b1111, 8'hE4);
    peek(3'd5, "R8 last executes");
    check(imem_addr === 3'd7, "R8 pc held", imem_addr, 7);

    // R9 load refused while busy
    load_pir(4'b0000);
    clear_imem();
    imem[4] = mk(2'b10, 3'd6, 1'b0, 2'b11, 2'd0, 4'b1111, 8'hE4);
    imem[5] = mk(2'b11, 3'd0, 1'b0, 2'b11, 2'd0, 4'b0, 8'h0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    pir_valid = 1'b1; pir_data = 4'b1111; #1;
    check(pir_ready === 1'b0, "R9 ready busy", pir_ready, 0);
    repeat (2) @(negedge clk);
    pir_valid = 1'b0;
    begin
      int cnt = 0;
      while (!done && cnt < 200) begin @(negedge clk); cnt++; end
    end
    mdl_mem[6] = mdl_apply(mdl_mem[6], 4'b0000, 2'b11, 2'd0, 4'b1111, 8'hE4);
    peek(3'd6, "R9 busy load ignored");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule